// File: doc/BRIEF.md
# SD Card Clock Prescaler Search Engine

This block finds the pair of prescaler settings that turns a fixed reference clock into a card clock as close to a requested frequency as the prescaler can reach. The prescaler divides the reference by `divide * (1 + rate)`. `divide` is an 8-bit field that may hold 2 to 253. `rate` is an 8-bit field that may hold 0 to 254. The achieved frequency is the floor of that quotient. The default reference is 96 MHz, and callers are expected to ask for 400 kHz to 48 MHz.

A caller puts the target in hertz on the target input and pulses `start_i` for one cycle. The engine then visits the candidate pairs in a fixed order: `divide` ascending in the outer loop and `rate` ascending in the inner loop. It stops on the first pair whose frequency equals the target. If no pair hits the target, it keeps the pair with the highest frequency strictly below the target, and on a tie the first such pair in visiting order wins. The engine tests each pair in one cycle by cross-multiplying, so it never divides during the scan. It runs a serial divider only when a pair becomes the new best, to learn that pair's exact frequency. A row whose frequencies have dropped to or below the current best is abandoned. The search ends early when the first entry of a row is already no better than the best. Neither shortcut changes which pair is chosen.

When the search ends, `done_o` pulses for one cycle. The chosen fields, the achieved frequency and a validity flag stay on the outputs until the next search completes. A search that finds no qualifying pair reports both fields and the frequency as zero, with the flag low.

Top module: `sdclk_div_search`

## Requirements
- R1: When `valid_o` is high, `freq_hz_o` equals floor(REF_HZ / (`div_o` * (1 + `rate_o`))).
- R2: When `valid_o` is high, `div_o` lies in [2, 253] and `rate_o` lies in [0, 254].
- R3: If some pair gives exactly the target, the result is the first such pair when `divide` ascends in the outer loop and `rate` ascends in the inner loop.
- R4: If no pair is exact, the result is the first pair in that order whose frequency is the largest value strictly below the target.
- R5: If no pair gives a frequency below or equal to the target, `div_o`, `rate_o` and `freq_hz_o` are all zero and `valid_o` is low.
- R6: A `start_i` pulse while `busy_o` is high has no effect. The result of the running search is unchanged.
- R7: `done_o` is high for exactly one cycle per search, and the four result outputs change only in the cycle in which `done_o` rises.
- R8: After reset, `busy_o`, `done_o` and `valid_o` are low and `div_o`, `rate_o` and `freq_hz_o` are zero.
- R9: `busy_o` is high from the first clock edge after an accepted `start_i` until `done_o` has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a search with the current target (ignored while busy) |
| target_hz_i | input | FREQ_W | Requested card clock in Hz, sampled at start |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when the result is on the outputs |
| valid_o | output | 1 | A qualifying pair was found |
| div_o | output | FIELD_W | Chosen divide field |
| rate_o | output | FIELD_W | Chosen rate field |
| freq_hz_o | output | FREQ_W | Achieved frequency in Hz, zero when invalid |

## Verification
The assertions assume three things. `start_i` is a single-cycle pulse. `target_hz_i` is valid in the cycle in which `start_i` is accepted. The reference constant fits the frequency width, so the cross-multiplied products cannot wrap in the comparator width. The stimulus changes `start_i` and the target only on the falling edge. It holds the target across the accepted pulse and keeps all targets within 32 bits. It issues a second start only while a search is already running, to exercise the ignore path. Each result is compared with an arithmetic model in the bench that runs the plain nested loop with true division. This model has no row pruning and no divider, so an error in either shortcut would show up as a mismatch.

// File: rtl/sdclk_div_pkg.sv
package sdclk_div_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SCAN   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_COMMIT = 3'd3,
    ST_DONE   = 3'd4
  } srch_state_e;

endpackage

// File: rtl/sdclk_pair_walk.sv
module sdclk_pair_walk #(
  parameter int unsigned FIELD_W  = 8,
  parameter int unsigned DIV_MIN  = 2,
  parameter int unsigned DIV_MAX  = 253,
  parameter int unsigned RATE_MAX = 254
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               next_row_i,
  output logic [FIELD_W-1:0] div_o,
  output logic [FIELD_W-1:0] rate_o,
  output logic               row_head_o,
  output logic               last_row_o,
  output logic               last_pair_o
);

  localparam logic [FIELD_W-1:0] DMIN = FIELD_W'(DIV_MIN);
  localparam logic [FIELD_W-1:0] DMAX = FIELD_W'(DIV_MAX);
  localparam logic [FIELD_W-1:0] RMAX = FIELD_W'(RATE_MAX);

  logic [FIELD_W-1:0] d_q, d_n;
  logic [FIELD_W-1:0] r_q, r_n;
  logic               en;

  assign en = load_i | step_i | next_row_i;

  always_comb begin
    d_n = d_q;
    r_n = r_q;
    if (load_i) begin
      d_n = DMIN;
      r_n = '0;
    end else if (next_row_i || (step_i && (r_q == RMAX))) begin
      d_n = d_q + FIELD_W'(1);
      r_n = '0;
    end else if (step_i) begin
      r_n = r_q + FIELD_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= DMIN;
      r_q <= '0;
    end else if (en) begin
      d_q <= d_n;
      r_q <= r_n;
    end
  end

  assign div_o       = d_q;
  assign rate_o      = r_q;
  assign row_head_o  = (r_q == '0);
  assign last_row_o  = (d_q == DMAX);
  assign last_pair_o = (d_q == DMAX) && (r_q == RMAX);

  // R2: the walked pair never leaves the legal field ranges
  p_walk_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_q >= DMIN) && (d_q <= DMAX) && (r_q <= RMAX));

endmodule

// File: rtl/sdclk_pair_judge.sv
module sdclk_pair_judge #(
  parameter int unsigned REF_HZ  = 96_000_000,
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned FIELD_W = 8,
  localparam int unsigned PROD_W = 2 * FIELD_W + 1
) (
  input  logic [FIELD_W-1:0] div_i,
  input  logic [FIELD_W-1:0] rate_i,
  input  logic [FREQ_W-1:0]  target_i,
  input  logic [FREQ_W-1:0]  best_i,
  output logic [PROD_W-1:0]  prod_o,
  output logic               exact_o,
  output logic               qualify_o,
  output logic               stale_o
);

  localparam int unsigned MUL_W = FREQ_W + PROD_W + 1;

  logic [MUL_W-1:0] ref_w;
  logic [MUL_W-1:0] lo_w;
  logic [MUL_W-1:0] hi_w;
  logic [MUL_W-1:0] best_hi_w;
  logic             below;
  logic             better;

  always_comb begin
    prod_o    = PROD_W'(div_i) * (PROD_W'(rate_i) + PROD_W'(1));
    ref_w     = MUL_W'(REF_HZ);
    lo_w      = MUL_W'(target_i) * MUL_W'(prod_o);
    hi_w      = (MUL_W'(target_i) + MUL_W'(1)) * MUL_W'(prod_o);
    best_hi_w = (MUL_W'(best_i) + MUL_W'(1)) * MUL_W'(prod_o);
    // floor(ref/p) == t  <=>  t*p <= ref < (t+1)*p
    exact_o   = (ref_w >= lo_w) && (ref_w < hi_w);
    // floor(ref/p) < t   <=>  ref < t*p
    below     = (ref_w < lo_w);
    // floor(ref/p) > b   <=>  ref >= (b+1)*p
    better    = (ref_w >= best_hi_w);
    qualify_o = below && better;
    stale_o   = !better;
  end

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
  parameter int unsigned DW = 32,
  parameter int unsigned VW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);

  localparam int unsigned CW = $clog2(DW + 1);
  localparam int unsigned MW = DW + VW + 1;

  logic          busy_q, busy_n;
  logic          done_q, done_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [VW-1:0] rem_q, rem_n;
  logic [DW-1:0] q_q, q_n;
  logic [VW-1:0] dsr_q, dsr_n;
  logic [DW-1:0] dvd_q, dvd_n;
  logic [VW:0]   trial;
  logic [VW:0]   diff;
  logic          ge;

  always_comb begin
    trial  = {rem_q, q_q[DW-1]};
    ge     = (trial >= {1'b0, dsr_q});
    diff   = trial - {1'b0, dsr_q};
    busy_n = busy_q;
    done_n = 1'b0;
    cnt_n  = cnt_q;
    rem_n  = rem_q;
    q_n    = q_q;
    dsr_n  = dsr_q;
    dvd_n  = dvd_q;
    if (start_i) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      rem_n  = '0;
      q_n    = dividend_i;
      dsr_n  = divisor_i;
      dvd_n  = dividend_i;
    end else if (busy_q) begin
      rem_n = ge ? diff[VW-1:0] : trial[VW-1:0];
      q_n   = {q_q[DW-2:0], ge};
      cnt_n = cnt_q + CW'(1);
      if (cnt_q == CW'(DW - 1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      q_q    <= '0;
      dsr_q  <= '0;
      dvd_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      if (start_i || busy_q) begin
        cnt_q <= cnt_n;
        rem_q <= rem_n;
        q_q   <= q_n;
      end
      if (start_i) begin
        dsr_q <= dsr_n;
        dvd_q <= dvd_n;
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = q_q;

  // R1: the finished quotient is the floor of dividend over divisor
  p_floor_quot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ((MW'(q_q) * MW'(dsr_q) <= MW'(dvd_q)) &&
                (MW'(dvd_q) < (MW'(q_q) + MW'(1)) * MW'(dsr_q))));

endmodule

// File: rtl/sdclk_div_search.sv
module sdclk_div_search
  import sdclk_div_pkg::*;
#(
  parameter int unsigned REF_HZ   = 96_000_000,
  parameter int unsigned FREQ_W   = 32,
  parameter int unsigned FIELD_W  = 8,
  parameter int unsigned DIV_MIN  = 2,
  parameter int unsigned DIV_MAX  = 253,
  parameter int unsigned RATE_MAX = 254
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FREQ_W-1:0]  target_hz_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               valid_o,
  output logic [FIELD_W-1:0] div_o,
  output logic [FIELD_W-1:0] rate_o,
  output logic [FREQ_W-1:0]  freq_hz_o
);

  localparam int unsigned PROD_W = 2 * FIELD_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  srch_state_e        state_q, state_n;
  logic [FREQ_W-1:0]  tgt_q;
  logic [FREQ_W-1:0]  found_q, found_n;
  logic [FIELD_W-1:0] best_d_q, best_d_n;
  logic [FIELD_W-1:0] best_r_q, best_r_n;
  logic               tgt_en, best_en;
  logic               res_en;
  logic [FIELD_W-1:0] res_d_q, res_r_q;
  logic [FREQ_W-1:0]  res_f_q;
  logic               res_v_q;

  logic               walk_load, walk_step, walk_row;
  logic [FIELD_W-1:0] cur_d, cur_r;
  logic               row_head, last_row, last_pair;
  logic [PROD_W-1:0]  cur_prod;
  logic               is_exact, is_qual, is_stale;
  logic               dv_start, dv_done;
  logic [FREQ_W-1:0]  dv_quot;

  sdclk_pair_walk #(
    .FIELD_W (FIELD_W),
    .DIV_MIN (DIV_MIN),
    .DIV_MAX (DIV_MAX),
    .RATE_MAX(RATE_MAX)
  ) walk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (walk_load),
    .step_i     (walk_step),
    .next_row_i (walk_row),
    .div_o      (cur_d),
    .rate_o     (cur_r),
    .row_head_o (row_head),
    .last_row_o (last_row),
    .last_pair_o(last_pair)
  );

  sdclk_pair_judge #(
    .REF_HZ (REF_HZ),
    .FREQ_W (FREQ_W),
    .FIELD_W(FIELD_W)
  ) judge_i (
    .div_i    (cur_d),
    .rate_i   (cur_r),
    .target_i (tgt_q),
    .best_i   (found_q),
    .prod_o   (cur_prod),
    .exact_o  (is_exact),
    .qualify_o(is_qual),
    .stale_o  (is_stale)
  );

  sdclk_divider #(
    .DW(FREQ_W),
    .VW(PROD_W)
  ) div_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .start_i   (dv_start),
    .dividend_i(FREQ_W'(REF_HZ)),
    .divisor_i (cur_prod),
    .done_o    (dv_done),
    .quot_o    (dv_quot)
  );

  always_comb begin
    state_n   = state_q;
    found_n   = found_q;
    best_d_n  = best_d_q;
    best_r_n  = best_r_q;
    tgt_en    = 1'b0;
    best_en   = 1'b0;
    res_en    = 1'b0;
    walk_load = 1'b0;
    walk_step = 1'b0;
    walk_row  = 1'b0;
    dv_start  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          tgt_en    = 1'b1;
          best_en   = 1'b1;
          found_n   = '0;
          best_d_n  = '0;
          best_r_n  = '0;
          walk_load = 1'b1;
          state_n   = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (is_exact) begin
          best_en  = 1'b1;
          found_n  = tgt_q;
          best_d_n = cur_d;
          best_r_n = cur_r;
          state_n  = ST_COMMIT;
        end else if (is_qual) begin
          best_en  = 1'b1;
          best_d_n = cur_d;
          best_r_n = cur_r;
          dv_start = 1'b1;
          state_n  = ST_WAIT;
        end else if (is_stale) begin
          if (row_head || last_row) state_n = ST_COMMIT;
          else                      walk_row = 1'b1;
        end else if (last_pair) begin
          state_n = ST_COMMIT;
        end else begin
          walk_step = 1'b1;
        end
      end
      ST_WAIT: begin
        if (dv_done) begin
          best_en = 1'b1;
          found_n = dv_quot;
          if (last_pair) state_n = ST_COMMIT;
          else begin
            walk_step = 1'b1;
            state_n   = ST_SCAN;
          end
        end
      end
      ST_COMMIT: begin
        res_en  = 1'b1;
        state_n = ST_DONE;
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      tgt_q    <= '0;
      found_q  <= '0;
      best_d_q <= '0;
      best_r_q <= '0;
      res_d_q  <= '0;
      res_r_q  <= '0;
      res_f_q  <= '0;
      res_v_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      if (tgt_en) tgt_q <= target_hz_i;
      if (best_en) begin
        found_q  <= found_n;
        best_d_q <= best_d_n;
        best_r_q <= best_r_n;
      end
      if (res_en) begin
        res_v_q <= (best_d_q != '0);
        res_d_q <= best_d_q;
        res_r_q <= best_r_q;
        res_f_q <= (best_d_q != '0) ? found_q : '0;
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign valid_o   = res_v_q;
  assign div_o     = res_d_q;
  assign rate_o    = res_r_q;
  assign freq_hz_o = res_f_q;

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: results move only when the completion pulse is shown
  p_result_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !done_o |-> ($stable(div_o) && $stable(rate_o) &&
                 $stable(freq_hz_o) && $stable(valid_o)));

  // R2: a valid result carries legal field values
  p_result_range_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    valid_o |-> ((div_o >= FIELD_W'(DIV_MIN)) && (div_o <= FIELD_W'(DIV_MAX)) &&
                 (rate_o <= FIELD_W'(RATE_MAX))));

  // R5: an invalid result is all zero
  p_invalid_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !valid_o |-> ((div_o == '0) && (rate_o == '0) && (freq_hz_o == '0)));

  // R4: a reported frequency never exceeds the requested one
  p_not_above_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && valid_o) |-> (freq_hz_o <= tgt_q));

  // R6: a running search keeps its captured target
  p_start_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy_o |=> $stable(tgt_q));

endmodule

// File: tb/sdclk_div_search_tb.sv
module sdclk_div_search_tb_top;

  localparam int unsigned REF = 96_000_000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] target;
  logic        busy, done, valid;
  logic [7:0]  dv, rt;
  logic [31:0] fq;

  int n_checks = 0;
  int n_fail   = 0;

  sdclk_div_search dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .target_hz_i(target),
    .busy_o     (busy),
    .done_o     (done),
    .valid_o    (valid),
    .div_o      (dv),
    .rate_o     (rt),
    .freq_hz_o  (fq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input longint got, input longint exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // plain nested search with true division
  task automatic model(input longint t, output longint md, output longint mr,
                       output longint mf, output longint mv);
    longint best = 0;
    md = 0; mr = 0;
    for (int d = 2; d <= 253; d++) begin
      for (int r = 0; r <= 254; r++) begin
        longint nf = longint'(REF) / (longint'(d) * longint'(1 + r));
        if (nf == t) begin
          md = d; mr = r; mf = nf; mv = 1;
          return;
        end
        if (nf < t && nf > best) begin
          best = nf; md = d; mr = r;
        end
      end
    end
    mf = best;
    mv = (md != 0) ? 1 : 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 80000; i++) begin
      @(negedge clk);
      if (done) begin
        ok = 1'b1;
        return;
      end
    end
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: no completion, got 0 expected 1");
  endtask

  task automatic run(input longint t, input bit disturb, input longint t2);
    longint md, mr, mf, mv;
    string  tag;
    bit     ok;
    model(t, md, mr, mf, mv);
    tag = (mf == t && mv == 1) ? "R3" : ((mv == 1) ? "R4" : "R5");
    @(negedge clk);
    start  = 1'b1;
    target = 32'(t);
    @(negedge clk);
    start = 1'b0;
    check("R9", "busy after start", longint'(busy), 1);
    if (disturb) begin
      // R6: a second start while running must not change the result
      start  = 1'b1;
      target = 32'(t2);
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(ok);
    if (!ok) return;
    check(tag, "divide", longint'(dv), md);
    check(tag, "rate", longint'(rt), mr);
    check("R1", "freq", longint'(fq), mf);
    check("R5", "valid", longint'(valid), mv);
    if (valid) begin
      check("R1", "formula", longint'(fq),
            longint'(REF) / (longint'(dv) * (1 + longint'(rt))));
      check("R2", "range", longint'(dv >= 8'd2 && dv <= 8'd253 && rt <= 8'd254), 1);
    end
    if (disturb) check("R6", "target of ignored start", longint'(dv), md);
    @(negedge clk);
    check("R7", "done width", longint'(done), 0);
    check("R9", "idle after done", longint'(busy), 0);
    for (int k = 0; k < 3; k++) @(negedge clk);
    check("R7", "hold divide", longint'(dv), md);
    check("R7", "hold freq", longint'(fq), mf);
  endtask

  initial begin
    start  = 1'b0;
    target = '0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "busy at reset", longint'(busy), 0);
    check("R8", "done at reset", longint'(done), 0);
    check("R8", "valid at reset", longint'(valid), 0);
    check("R8", "fields at reset", longint'({dv, rt}), 0);
    check("R8", "freq at reset", longint'(fq), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run(400_000, 1'b0, 0);
    run(25_000_000, 1'b0, 0);
    run(48_000_000, 1'b0, 0);
    run(24_000_000, 1'b0, 0);
    run(19_200_000, 1'b0, 0);
    run(7_000_000, 1'b0, 0);
    run(13_000_000, 1'b0, 0);
    run(333_333, 1'b0, 0);
    run(1_234_567, 1'b0, 0);
    run(12_345_678, 1'b0, 0);
    run(47_999_999, 1'b0, 0);
    run(60_000_000, 1'b0, 0);
    run(3_000_000, 1'b1, 400_000);
    run(1_000, 1'b0, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule